// File: doc/BRIEF.md
# Victim/Next-Victim Replacement Unit

This block chooses which way of an N-way set-associative cache gets overwritten when a lookup misses. It keeps no recency order. For each set it stores only two pointers. The first names the block that leaves next, called the victim. The second names the block in line after it, called the next victim. Every other way in the set counts as ordinary and carries no state. Hits and misses move these two pointers. Whenever a new next victim is needed, it is drawn from the ordinary ways by a free-running pseudo-random generator.

The cache controller presents one access per cycle. It gives a strobe, the set index, a hit flag with the hitting way, a miss flag, and the valid bits of the addressed set. The replacement way is a combinational function of the addressed set's stored pointers and the valid bits. It can therefore be read in the same cycle as the miss that uses it. The pointer update lands on the next rising clock edge. Tag storage, data storage and the refill sequence belong to the surrounding cache.

Top module: `vnv_replacer`

## Requirements
- R1: After reset every set holds victim = way 0 (marked present) and next victim = way 1. On a fresh set with all ways valid, the first miss replaces way 0 and the second replaces way 1.
- R2: If any bit of `valid_vec_i` is 0, `repl_way_o` is the lowest-numbered way whose valid bit is 0. A miss that fills such an invalid way leaves both pointers and the victim-present flag unchanged.
- R3: On a miss with all ways valid and the victim present, `repl_way_o` equals the victim. The old next victim then becomes the victim. The new next victim is a way that was neither the old victim nor the old next victim.
- R4: A hit on the present victim clears the victim-present flag, so that way becomes ordinary. The next all-valid miss replaces the next victim. That way is then promoted to victim, and a fresh next victim is drawn that differs from it and from the cleared victim's way.
- R5: A hit on the next victim leaves the victim unchanged. It draws a new next victim from the ways that are neither the victim pointer nor the old next victim.
- R6: A hit on an ordinary way changes no state.
- R7: State changes only when `acc_valid_i` is high and exactly one of `hit_i` and `miss_i` is high. An access with both flags high, or with the strobe low, is ignored. `repl_way_o` still reflects the addressed set at all times.
- R8: Each set's pointers change only on accesses that address that set.
- R9: The victim and next-victim pointers of a set always name different ways.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_valid_i | input | 1 | Access strobe |
| set_i | input | $clog2(NUM_SETS) | Addressed set |
| hit_i | input | 1 | Access hit |
| hit_way_i | input | $clog2(NUM_WAYS) | Way that hit |
| miss_i | input | 1 | Access missed |
| valid_vec_i | input | NUM_WAYS | Valid bits of the addressed set, bit n = way n |
| repl_way_o | output | $clog2(NUM_WAYS) | Way to fill on a miss |

## Verification
A hit flag and a miss flag can be raised together on one access. The same applies to a miss and a state-changing hit landing on different sets in consecutive cycles. The bench raises both flags on one strobed access, and also holds the miss flag with the strobe low. It then checks that the following misses on that set replay the reset order 0 then 1, which is only possible if nothing moved. The random draws are judged by membership: a reference model in the monitor tracks, per set, the set of ways each pointer may hold, narrows them as replacements reveal them, and requires every reported way to lie inside the allowed set.

// File: rtl/vnv_pkg.sv
package vnv_pkg;
  typedef enum logic [1:0] {
    ACC_IDLE,
    ACC_MISS,
    ACC_HIT
  } acc_kind_e;

  typedef enum logic [1:0] {
    HIT_ON_VICTIM,
    HIT_ON_NEXT,
    HIT_ON_ORDINARY
  } hit_class_e;
endpackage

// File: rtl/vnv_lfsr.sv
module vnv_lfsr #(
  parameter int unsigned       WIDTH = 16,
  parameter logic [WIDTH-1:0]  TAPS  = 'hB400,
  parameter logic [WIDTH-1:0]  SEED  = 'h1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [WIDTH-1:0] rnd_o
);
  logic [WIDTH-1:0] state_q;

  // Galois form, advances every cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SEED;
    else if (state_q[0]) state_q <= (state_q >> 1) ^ TAPS;
    else state_q <= state_q >> 1;
  end

  assign rnd_o = state_q;

  assert_lfsr_live_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != '0);
endmodule

// File: rtl/vnv_pick.sv
module vnv_pick #(
  parameter int unsigned NUM_WAYS = 4,
  parameter int unsigned RND_W    = 16,
  localparam int unsigned WAY_W   = $clog2(NUM_WAYS)
) (
  input  logic [RND_W-1:0] rnd_i,
  input  logic [WAY_W-1:0] excl_a_i,
  input  logic [WAY_W-1:0] excl_b_i,
  output logic [WAY_W-1:0] pick_o
);
  // First non-excluded way at or after a random start, wrapping
  always_comb begin
    int   start;
    int   cand;
    logic found;
    start  = int'(rnd_i % RND_W'(NUM_WAYS));
    found  = 1'b0;
    pick_o = '0;
    for (int k = 0; k < int'(NUM_WAYS); k++) begin
      cand = (start + k) % int'(NUM_WAYS);
      if (!found && (WAY_W'(cand) != excl_a_i) && (WAY_W'(cand) != excl_b_i)) begin
        pick_o = WAY_W'(cand);
        found  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/vnv_set_table.sv
module vnv_set_table #(
  parameter int unsigned NUM_SETS = 16,
  parameter int unsigned NUM_WAYS = 4,
  localparam int unsigned SET_W   = $clog2(NUM_SETS),
  localparam int unsigned WAY_W   = $clog2(NUM_WAYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SET_W-1:0] rd_set_i,
  output logic [WAY_W-1:0] rd_v_o,
  output logic [WAY_W-1:0] rd_nv_o,
  output logic             rd_vok_o,
  input  logic             wr_en_i,
  input  logic [SET_W-1:0] wr_set_i,
  input  logic [WAY_W-1:0] wr_v_i,
  input  logic [WAY_W-1:0] wr_nv_i,
  input  logic             wr_vok_i
);
  logic [WAY_W-1:0] v_q   [NUM_SETS];
  logic [WAY_W-1:0] nv_q  [NUM_SETS];
  logic             vok_q [NUM_SETS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < int'(NUM_SETS); s++) begin
        v_q[s]   <= WAY_W'(0);
        nv_q[s]  <= WAY_W'(1);
        vok_q[s] <= 1'b1;
      end
    end else if (wr_en_i) begin
      v_q[wr_set_i]   <= wr_v_i;
      nv_q[wr_set_i]  <= wr_nv_i;
      vok_q[wr_set_i] <= wr_vok_i;
    end
  end

  assign rd_v_o   = v_q[rd_set_i];
  assign rd_nv_o  = nv_q[rd_set_i];
  assign rd_vok_o = vok_q[rd_set_i];

  for (genvar s = 0; s < int'(NUM_SETS); s++) begin : g_chk
    assert_ptrs_distinct_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      v_q[s] != nv_q[s]);
  end
endmodule

// File: rtl/vnv_ctrl.sv
module vnv_ctrl
  import vnv_pkg::*;
#(
  parameter int unsigned NUM_WAYS = 4,
  localparam int unsigned WAY_W   = $clog2(NUM_WAYS)
) (
  input  logic                acc_valid_i,
  input  logic                hit_i,
  input  logic [WAY_W-1:0]    hit_way_i,
  input  logic                miss_i,
  input  logic [NUM_WAYS-1:0] valid_vec_i,
  input  logic [WAY_W-1:0]    cur_v_i,
  input  logic [WAY_W-1:0]    cur_nv_i,
  input  logic                cur_vok_i,
  input  logic [WAY_W-1:0]    pick_i,
  output logic [WAY_W-1:0]    repl_way_o,
  output logic                wr_en_o,
  output logic [WAY_W-1:0]    wr_v_o,
  output logic [WAY_W-1:0]    wr_nv_o,
  output logic                wr_vok_o
);
  acc_kind_e        kind;
  hit_class_e       hclass;
  logic             all_valid;
  logic [WAY_W-1:0] first_inv;

  always_comb begin
    if (acc_valid_i && miss_i && !hit_i)      kind = ACC_MISS;
    else if (acc_valid_i && hit_i && !miss_i) kind = ACC_HIT;
    else                                      kind = ACC_IDLE;
  end

  always_comb begin
    if (cur_vok_i && (hit_way_i == cur_v_i)) hclass = HIT_ON_VICTIM;
    else if (hit_way_i == cur_nv_i)          hclass = HIT_ON_NEXT;
    else                                     hclass = HIT_ON_ORDINARY;
  end

  assign all_valid = &valid_vec_i;

  always_comb begin
    first_inv = '0;
    for (int w = int'(NUM_WAYS) - 1; w >= 0; w--) begin
      if (!valid_vec_i[w]) first_inv = WAY_W'(w);
    end
  end

  // invalid ways first, then victim, then next victim when victim was released
  always_comb begin
    if (!all_valid)     repl_way_o = first_inv;
    else if (cur_vok_i) repl_way_o = cur_v_i;
    else                repl_way_o = cur_nv_i;
  end

  always_comb begin
    wr_en_o  = 1'b0;
    wr_v_o   = cur_v_i;
    wr_nv_o  = cur_nv_i;
    wr_vok_o = cur_vok_i;
    unique case (kind)
      ACC_MISS: begin
        if (all_valid) begin
          // next victim moves up in both victim-present and released cases
          wr_en_o  = 1'b1;
          wr_v_o   = cur_nv_i;
          wr_vok_o = 1'b1;
          wr_nv_o  = pick_i;
        end
      end
      ACC_HIT: begin
        unique case (hclass)
          HIT_ON_VICTIM: begin
            wr_en_o  = 1'b1;
            wr_vok_o = 1'b0;
          end
          HIT_ON_NEXT: begin
            wr_en_o = 1'b1;
            wr_nv_o = pick_i;
          end
          default: ;
        endcase
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/vnv_replacer.sv
module vnv_replacer #(
  parameter int unsigned NUM_SETS = 16,
  parameter int unsigned NUM_WAYS = 4,
  parameter int unsigned LFSR_W   = 16,
  localparam int unsigned SET_W   = $clog2(NUM_SETS),
  localparam int unsigned WAY_W   = $clog2(NUM_WAYS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                acc_valid_i,
  input  logic [SET_W-1:0]    set_i,
  input  logic                hit_i,
  input  logic [WAY_W-1:0]    hit_way_i,
  input  logic                miss_i,
  input  logic [NUM_WAYS-1:0] valid_vec_i,
  output logic [WAY_W-1:0]    repl_way_o
);
  logic [LFSR_W-1:0] rnd;
  logic [WAY_W-1:0]  rd_v, rd_nv, pick;
  logic              rd_vok;
  logic              wr_en, wr_vok;
  logic [WAY_W-1:0]  wr_v, wr_nv;

  vnv_lfsr #(.WIDTH(LFSR_W)) u_lfsr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rnd_o (rnd)
  );

  vnv_set_table #(.NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS)) u_table (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_set_i(set_i),
    .rd_v_o  (rd_v),
    .rd_nv_o (rd_nv),
    .rd_vok_o(rd_vok),
    .wr_en_i (wr_en),
    .wr_set_i(set_i),
    .wr_v_i  (wr_v),
    .wr_nv_i (wr_nv),
    .wr_vok_i(wr_vok)
  );

  vnv_pick #(.NUM_WAYS(NUM_WAYS), .RND_W(LFSR_W)) u_pick (
    .rnd_i   (rnd),
    .excl_a_i(rd_v),
    .excl_b_i(rd_nv),
    .pick_o  (pick)
  );

  vnv_ctrl #(.NUM_WAYS(NUM_WAYS)) u_ctrl (
    .acc_valid_i(acc_valid_i),
    .hit_i      (hit_i),
    .hit_way_i  (hit_way_i),
    .miss_i     (miss_i),
    .valid_vec_i(valid_vec_i),
    .cur_v_i    (rd_v),
    .cur_nv_i   (rd_nv),
    .cur_vok_i  (rd_vok),
    .pick_i     (pick),
    .repl_way_o (repl_way_o),
    .wr_en_o    (wr_en),
    .wr_v_o     (wr_v),
    .wr_nv_o    (wr_nv),
    .wr_vok_o   (wr_vok)
  );

  logic miss_ev, hit_ev, fill_inv, miss_full, hit_v, hit_o;
  assign miss_ev   = acc_valid_i && miss_i && !hit_i;
  assign hit_ev    = acc_valid_i && hit_i && !miss_i;
  assign fill_inv  = miss_ev && !(&valid_vec_i);
  assign miss_full = miss_ev && (&valid_vec_i);
  assign hit_v     = hit_ev && rd_vok && (hit_way_i == rd_v);
  assign hit_o     = hit_ev && !hit_v && (hit_way_i != rd_nv);

  assert_fill_invalid_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_inv |-> !valid_vec_i[repl_way_o]);

  assert_fill_keeps_ptrs_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(fill_inv) && set_i == $past(set_i)) |->
      (rd_v == $past(rd_v) && rd_nv == $past(rd_nv) && rd_vok == $past(rd_vok)));

  assert_repl_victim_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miss_full && rd_vok) |-> repl_way_o == rd_v);

  assert_miss_shift_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(miss_full) && set_i == $past(set_i)) |->
      (rd_vok && rd_v == $past(rd_nv) && rd_nv != $past(rd_nv) && rd_nv != $past(rd_v)));

  assert_hit_victim_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(hit_v) && set_i == $past(set_i)) |->
      (!rd_vok && rd_v == $past(rd_v) && rd_nv == $past(rd_nv)));

  assert_pick_ordinary_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pick != rd_v && pick != rd_nv);

  assert_hit_ordinary_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(hit_o) && set_i == $past(set_i)) |->
      (rd_v == $past(rd_v) && rd_nv == $past(rd_nv) && rd_vok == $past(rd_vok)));

  assert_both_flags_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(acc_valid_i && hit_i && miss_i) && set_i == $past(set_i)) |->
      (rd_v == $past(rd_v) && rd_nv == $past(rd_nv) && rd_vok == $past(rd_vok)));
endmodule

// File: tb/vnv_replacer_tb.sv
`timescale 1ns/1ps
module vnv_replacer_tb;
  localparam int NW = 4;
  localparam int NS = 16;
  localparam int WW = 2;
  localparam int SW = 4;
  localparam logic [NW-1:0] ALL = '1;

  // op kinds
  localparam int K_PEEK = 0;
  localparam int K_MISS = 1;
  localparam int K_HIT  = 2;
  localparam int K_BOTH = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc = 1'b0, hit = 1'b0, miss = 1'b0;
  logic [SW-1:0] set = '0;
  logic [WW-1:0] hway = '0;
  logic [NW-1:0] vvec = '1;
  logic [WW-1:0] repl;

  always #2 clk = ~clk;

  vnv_replacer u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .acc_valid_i(acc),
    .set_i      (set),
    .hit_i      (hit),
    .hit_way_i  (hway),
    .miss_i     (miss),
    .valid_vec_i(vvec),
    .repl_way_o (repl)
  );

  typedef struct {
    int            kind;
    int            s;
    int            way;
    logic [NW-1:0] vv;
    string         req;
  } item_t;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model: each pointer held as the mask of ways it may name
  logic [NW-1:0] m_v  [NS];
  logic [NW-1:0] m_nv [NS];
  bit            m_vok[NS];

  function automatic bit is_oh(logic [NW-1:0] m);
    return (m != '0) && ((m & (m - 1'b1)) == '0);
  endfunction

  function automatic logic [NW-1:0] excl_mask(int s);
    logic [NW-1:0] e = '0;
    if (is_oh(m_v[s]))  e |= m_v[s];
    if (is_oh(m_nv[s])) e |= m_nv[s];
    return e;
  endfunction

  function automatic logic [NW-1:0] low_invalid(logic [NW-1:0] vv);
    for (int w = NW - 1; w >= 0; w--) if (!vv[w]) low_invalid = NW'(1) << w;
  endfunction

  task automatic op(input int kind, input int s, input int way,
                    input logic [NW-1:0] vv, input string req);
    item_t it;
    @(posedge clk); #1;
    acc  = (kind != K_PEEK);
    miss = (kind == K_PEEK) || (kind == K_MISS) || (kind == K_BOTH);
    hit  = (kind == K_HIT) || (kind == K_BOTH);
    set  = SW'(s);
    hway = WW'(way);
    vvec = vv;
    it = '{kind, s, way, vv, req};
    q.push_back(it);
  endtask

  task automatic idle();
    @(posedge clk); #1;
    acc = 1'b0; hit = 1'b0; miss = 1'b0; vvec = ALL;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      logic [NW-1:0] exp, act, ex;
      it  = q.pop_front();
      act = NW'(1) << repl;
      if (it.kind != K_HIT) begin
        if (it.vv != ALL)       exp = low_invalid(it.vv);
        else if (m_vok[it.s])   exp = m_v[it.s];
        else                    exp = m_nv[it.s];
        checks++;
        if ((exp & act) == '0) begin
          errors++;
          $display("FAIL %s: set %0d repl_way_o=%0d expected one of %b",
                   it.req, it.s, repl, exp);
        end
      end
      if (it.kind == K_MISS && it.vv == ALL) begin
        if (m_vok[it.s]) m_v[it.s] = act;
        else             m_nv[it.s] = act;
        if (is_oh(m_v[it.s])) m_nv[it.s] &= ~m_v[it.s];
        ex = excl_mask(it.s);
        m_v[it.s]   = m_nv[it.s];
        m_vok[it.s] = 1'b1;
        m_nv[it.s]  = ~ex;
      end else if (it.kind == K_HIT) begin
        logic [NW-1:0] w;
        w = NW'(1) << it.way;
        if (m_vok[it.s] && m_v[it.s] == w)  m_vok[it.s] = 1'b0;
        else if (m_nv[it.s] == w)           m_nv[it.s] = ~excl_mask(it.s);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < NS; s++) begin
      m_v[s] = 4'b0001; m_nv[s] = 4'b0010; m_vok[s] = 1'b1;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset order, R7 peek with strobe low
    op(K_PEEK, 0, 0, ALL, "R1_R7 peek");
    op(K_MISS, 0, 0, ALL, "R1 first miss");
    op(K_MISS, 0, 0, ALL, "R1 second miss");
    op(K_MISS, 0, 0, ALL, "R3 third miss");

    // R2 invalid ways win and leave state alone
    op(K_MISS, 2, 0, 4'b1011, "R2 fill way2");
    op(K_MISS, 2, 0, 4'b0110, "R2 fill way0");
    op(K_MISS, 2, 0, 4'b0111, "R2 fill way3");
    op(K_MISS, 2, 0, ALL, "R2 state kept v");
    op(K_MISS, 2, 0, ALL, "R2 state kept nv");

    // R4 hit on victim releases it
    op(K_HIT,  3, 0, ALL, "R4 hit");
    op(K_MISS, 3, 0, ALL, "R4 replaces next victim");
    op(K_MISS, 3, 0, ALL, "R4 promoted way");
    op(K_MISS, 3, 0, ALL, "R4 fresh draw");

    // R5 hit on next victim redraws it
    op(K_HIT,  4, 1, ALL, "R5 hit");
    op(K_MISS, 4, 0, ALL, "R5 victim kept");
    op(K_MISS, 4, 0, ALL, "R5 redrawn next");

    // R4/R5 released victim still excluded from draws
    op(K_HIT,  10, 0, ALL, "R4 release");
    op(K_HIT,  10, 1, ALL, "R5 redraw");
    op(K_MISS, 10, 0, ALL, "R4_R5 stale excluded");

    // R6 ordinary hit
    op(K_HIT,  5, 3, ALL, "R6 hit");
    op(K_HIT,  5, 2, ALL, "R6 hit");
    op(K_MISS, 5, 0, ALL, "R6 v unchanged");
    op(K_MISS, 5, 0, ALL, "R6 nv unchanged");

    // R7 both flags, and strobe low
    op(K_BOTH, 6, 0, ALL, "R7 both flags");
    op(K_BOTH, 6, 1, ALL, "R7 both flags");
    op(K_PEEK, 6, 0, ALL, "R7 strobe low");
    op(K_MISS, 6, 0, ALL, "R7 v unchanged");
    op(K_MISS, 6, 0, ALL, "R7 nv unchanged");

    // R8 interleaved sets
    op(K_MISS, 7, 0, ALL, "R8 set7");
    op(K_MISS, 8, 0, ALL, "R8 set8");
    op(K_MISS, 7, 0, ALL, "R8 set7");
    op(K_HIT,  8, 1, ALL, "R8 set8 hit");
    op(K_MISS, 7, 0, ALL, "R8 set7");
    op(K_MISS, 8, 0, ALL, "R8 set8");

    // R3 long run of misses on one set
    for (int i = 0; i < 40; i++) op(K_MISS, 9, 0, ALL, "R3 run");

    idle();
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule